// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one 16-bit down-counting timer channel. It advances once for each cycle in which `tick_en` is high, and it drives a single output pin whose waveform depends on one of six operating modes. A separate host-side block handles byte sequencing. That block writes a mode, a BCD flag and a full 16-bit initial count into this channel with one strobe. The live count is always visible, and it can be captured into a held register for a later read. A count of zero means 65536 ticks.

A rising edge on `gate` restarts the period in the retriggerable modes. A low `gate` pauses counting in the two software-started modes. The BCD flag is stored and shown on an output, but counting is always binary.

The configuration and count come in through a plain strobe with no back-pressure: `load_stb` is accepted in the cycle it is high. A tick in the same cycle as a load is discarded. The channel is never busy, so it has no ready signal.

Top module: `interval_counter_channel`

## Requirements
- R1: A loaded count of 0 runs as 65536 ticks. In mode 0, the output is still low after 65535 ticks and goes high at tick 65536.
- R2: Mode 0 (terminal-count flag): the output is low after a load, rises once the tick count reaches N, and then stays high until the next load.
- R3: Mode 1 (gate-retriggered one-shot): the output is low for the first N ticks after a load or a gate rising edge, and high from then on. A gate rising edge reloads the count.
- R4: Mode 2 (rate generator): the count runs N..1 and reloads to N. The output is high for exactly the one tick interval after each reload and low otherwise. A gate rising edge restarts the period.
- R5: Mode 3 (square wave): within each N-tick period, the output is high while the remaining count exceeds floor(N/2), that is for (N+1)/2 ticks, and low for the rest. A gate rising edge restarts the period.
- R6: Mode 4 (software strobe): the output is high for exactly one tick interval, starting when the tick count since the load equals N.
- R7: Mode 5 (gate strobe): this mode behaves like mode 4, except that a gate rising edge also restarts the count.
- R8: A `load_mode` value of 6 behaves as mode 2, and a value of 7 behaves as mode 3.
- R9: After reset, the channel is in mode 3 with count 65536: `cur_count` reads 0, `out_level` is high, and `held_count` and `cfg_bcd` are 0.
- R10: In modes 0 and 4, ticks are ignored while `gate` is low, and counting resumes when `gate` is high.
- R11: A load puts the new count on `cur_count` in the next cycle and returns the output to the mode's initial level. A tick in the same cycle as the load has no effect.
- R12: In modes 0, 1, 4 and 5, the count keeps decrementing past terminal count, wrapping modulo 65536 (0, then 0xFFFF, then 0xFFFE, and so on).
- R13: `latch_stb` copies the current count into `held_count`, which then holds that value while counting continues. The loaded BCD flag appears on `cfg_bcd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable, one tick per high cycle |
| gate | input | 1 | Gate input: level pauses modes 0/4, rising edge retriggers modes 1/2/3/5 |
| load_stb | input | 1 | Load mode, BCD flag and initial count |
| load_mode | input | 3 | Mode code 0..7 (6 and 7 fold to 2 and 3) |
| load_bcd | input | 1 | BCD flag to store |
| load_value | input | 16 | Initial count, 0 means 65536 |
| latch_stb | input | 1 | Capture the current count into held_count |
| out_level | output | 1 | Channel output waveform |
| cur_count | output | 16 | Live count value |
| held_count | output | 16 | Last latched count |
| cfg_bcd | output | 1 | Stored BCD flag |

## Verification
A table of mode, count and tick-number rows checks the output and count at chosen points after a fresh load. The sample points sit just before, at and after the terminal or reload tick, so a one-tick timing slip in any mode shows up. Odd and even square-wave periods separate (N+1)/2 from N/2. The period-1 case catches a broken reload compare, and the samples past terminal count catch a missing 16-bit wrap. Directed sequences then cover the following:
- gate retrigger in each retriggerable mode;
- the gate-low pause;
- the full 65536-tick zero count;
- a load that coincides with a tick;
- latch holding while the count moves on.

// File: rtl/icc_pkg.sv
`timescale 1ns/1ps
package icc_pkg;
  typedef enum logic [2:0] {
    MODE_TC_FLAG    = 3'd0,
    MODE_ONESHOT    = 3'd1,
    MODE_RATE       = 3'd2,
    MODE_SQUARE     = 3'd3,
    MODE_SW_STROBE  = 3'd4,
    MODE_HW_STROBE  = 3'd5
  } icc_mode_e;

  // codes 6 and 7 fold onto the rate and square modes
  function automatic icc_mode_e fold_mode(input logic [2:0] code);
    if (code[2] && code[1]) return icc_mode_e'({1'b0, code[1:0]});
    return icc_mode_e'(code);
  endfunction
endpackage

// File: rtl/icc_gate_edge.sv
`timescale 1ns/1ps
module icc_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  output logic rise
);
  logic gate_q;

  // starts high so a gate held high through reset is not seen as an edge
  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= 1'b1;
    else        gate_q <= gate;
  end

  assign rise = gate & ~gate_q;
endmodule

// File: rtl/icc_down_counter.sv
`timescale 1ns/1ps
module icc_down_counter #(
  parameter int CNT_W = 16,
  localparam int EXT_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [EXT_W-1:0] start_val,
  input  logic             tick,
  input  logic             periodic,
  output logic [EXT_W-1:0] rem,
  output logic             term,
  output logic             hit
);
  localparam logic [EXT_W-1:0] FULL = EXT_W'(1) << CNT_W;
  localparam logic [EXT_W-1:0] ONE  = EXT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem  <= FULL;
      term <= 1'b0;
      hit  <= 1'b0;
    end else if (restart) begin
      rem  <= start_val;
      term <= 1'b0;
      hit  <= 1'b0;
    end else if (tick) begin
      if (rem == ONE && periodic) begin
        rem <= start_val;
        hit <= 1'b1;
      end else if (rem == ONE && !term) begin
        rem  <= '0;
        term <= 1'b1;
        hit  <= 1'b1;
      end else begin
        hit <= 1'b0;
        if (term) rem <= {1'b0, rem[CNT_W-1:0] - CNT_W'(1)};
        else      rem <= rem - ONE;
      end
    end
  end

  p_term_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (term && !restart) |=> term);

  p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && tick && !periodic) |=> !hit);

  p_period_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    periodic |-> (rem != '0));
endmodule

// File: rtl/icc_wave_sel.sv
`timescale 1ns/1ps
module icc_wave_sel
  import icc_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int EXT_W = CNT_W + 1
) (
  input  icc_mode_e        mode,
  input  logic [EXT_W-1:0] rem,
  input  logic [EXT_W-1:0] period,
  input  logic             term,
  input  logic             hit,
  output logic             out
);
  logic [EXT_W-1:0] half;
  assign half = period >> 1;

  always_comb begin
    unique case (mode)
      MODE_TC_FLAG, MODE_ONESHOT: out = term;
      MODE_SQUARE:                out = (rem > half);
      default:                    out = hit;
    endcase
  end
endmodule

// File: rtl/interval_counter_channel.sv
`timescale 1ns/1ps
module interval_counter_channel
  import icc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             gate,
  input  logic             load_stb,
  input  logic [2:0]       load_mode,
  input  logic             load_bcd,
  input  logic [CNT_W-1:0] load_value,
  input  logic             latch_stb,
  output logic             out_level,
  output logic [CNT_W-1:0] cur_count,
  output logic [CNT_W-1:0] held_count,
  output logic             cfg_bcd
);
  localparam int EXT_W = CNT_W + 1;
  localparam logic [EXT_W-1:0] FULL = EXT_W'(1) << CNT_W;

  icc_mode_e        mode_q;
  logic [EXT_W-1:0] period_q;
  logic [EXT_W-1:0] load_ext, start_val, rem;
  logic             gate_rise, retrig, gated, periodic;
  logic             restart, tick_eff, term, hit;

  assign load_ext = {load_value == '0, load_value};

  always_comb begin
    retrig   = (mode_q == MODE_ONESHOT) || (mode_q == MODE_RATE) ||
               (mode_q == MODE_SQUARE)  || (mode_q == MODE_HW_STROBE);
    gated    = (mode_q == MODE_TC_FLAG) || (mode_q == MODE_SW_STROBE);
    periodic = (mode_q == MODE_RATE)    || (mode_q == MODE_SQUARE);
  end

  assign restart   = load_stb | (gate_rise & retrig);
  assign start_val = load_stb ? load_ext : period_q;
  assign tick_eff  = tick_en & (gate | ~gated);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= MODE_SQUARE;
      period_q   <= FULL;
      cfg_bcd    <= 1'b0;
      held_count <= '0;
    end else begin
      if (load_stb) begin
        mode_q   <= fold_mode(load_mode);
        period_q <= load_ext;
        cfg_bcd  <= load_bcd;
      end
      if (latch_stb) held_count <= rem[CNT_W-1:0];
    end
  end

  icc_gate_edge u_edge (
    .clk(clk), .rst_n(rst_n), .gate(gate), .rise(gate_rise)
  );

  icc_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(restart), .start_val(start_val),
    .tick(tick_eff), .periodic(periodic), .rem(rem), .term(term), .hit(hit)
  );

  icc_wave_sel #(.CNT_W(CNT_W)) u_wave (
    .mode(mode_q), .rem(rem), .period(period_q), .term(term), .hit(hit),
    .out(out_level)
  );

  assign cur_count = rem[CNT_W-1:0];

  p_load_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> (cur_count == $past(load_value)));

  p_tc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_TC_FLAG && out_level && !load_stb) |=> out_level);

  p_gate_pause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (gated && !gate && !restart) |=> $stable(cur_count));
endmodule

// File: tb/test_interval_counter_channel.sv
`timescale 1ns/1ps
module test_interval_counter_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, gate = 1'b1, load_stb = 1'b0, load_bcd = 1'b0;
  logic        latch_stb = 1'b0;
  logic [2:0]  load_mode = '0;
  logic [15:0] load_value = '0;
  logic        out_level, cfg_bcd;
  logic [15:0] cur_count, held_count;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  interval_counter_channel i_interval_counter_channel (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate(gate),
    .load_stb(load_stb), .load_mode(load_mode), .load_bcd(load_bcd),
    .load_value(load_value), .latch_stb(latch_stb), .out_level(out_level),
    .cur_count(cur_count), .held_count(held_count), .cfg_bcd(cfg_bcd)
  );

  // {mode, count, ticks after load, expected out, expected count}
  localparam int NV = 24;
  localparam logic [43:0] VEC [NV] = '{
    {3'd0, 16'd5, 8'd0, 1'b0, 16'h0005},
    {3'd0, 16'd5, 8'd4, 1'b0, 16'h0001},
    {3'd0, 16'd5, 8'd5, 1'b1, 16'h0000},
    {3'd0, 16'd5, 8'd7, 1'b1, 16'hFFFE},
    {3'd1, 16'd3, 8'd2, 1'b0, 16'h0001},
    {3'd1, 16'd3, 8'd3, 1'b1, 16'h0000},
    {3'd2, 16'd4, 8'd3, 1'b0, 16'h0001},
    {3'd2, 16'd4, 8'd4, 1'b1, 16'h0004},
    {3'd2, 16'd4, 8'd5, 1'b0, 16'h0003},
    {3'd2, 16'd4, 8'd8, 1'b1, 16'h0004},
    {3'd2, 16'd1, 8'd1, 1'b1, 16'h0001},
    {3'd3, 16'd5, 8'd0, 1'b1, 16'h0005},
    {3'd3, 16'd5, 8'd2, 1'b1, 16'h0003},
    {3'd3, 16'd5, 8'd3, 1'b0, 16'h0002},
    {3'd3, 16'd5, 8'd5, 1'b1, 16'h0005},
    {3'd3, 16'd4, 8'd1, 1'b1, 16'h0003},
    {3'd3, 16'd4, 8'd2, 1'b0, 16'h0002},
    {3'd4, 16'd3, 8'd2, 1'b0, 16'h0001},
    {3'd4, 16'd3, 8'd3, 1'b1, 16'h0000},
    {3'd4, 16'd3, 8'd4, 1'b0, 16'hFFFF},
    {3'd5, 16'd2, 8'd2, 1'b1, 16'h0000},
    {3'd6, 16'd3, 8'd3, 1'b1, 16'h0003},
    {3'd7, 16'd6, 8'd2, 1'b1, 16'h0004},
    {3'd7, 16'd6, 8'd3, 1'b0, 16'h0003}
  };

  function automatic string req_of(input logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic do_load(input logic [2:0] m, input logic [15:0] v, input logic b);
    load_mode = m; load_value = v; load_bcd = b; load_stb = 1'b1;
    @(negedge clk);
    load_stb = 1'b0;
  endtask

  task automatic do_ticks(input int k);
    if (k > 0) begin
      tick_en = 1'b1;
      repeat (k) @(posedge clk);
      @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  task automatic retrigger();
    gate = 1'b0;
    @(negedge clk);
    gate = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #750000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state
    check("R9", {31'd0, out_level}, 32'd1);
    check("R9", {16'd0, cur_count}, 32'd0);
    check("R9", {16'd0, held_count}, 32'd0);
    check("R9", {31'd0, cfg_bcd}, 32'd0);
    do_ticks(1);
    check("R9", {15'd0, out_level, cur_count}, {15'd0, 1'b1, 16'hFFFF});

    // table walk: fresh load, k ticks, sample out and count
    for (int i = 0; i < NV; i++) begin
      do_load(VEC[i][43:41], VEC[i][40:25], 1'b0);
      do_ticks(int'(VEC[i][24:17]));
      check(req_of(VEC[i][43:41]), {31'd0, out_level}, {31'd0, VEC[i][16]});
      check(req_of(VEC[i][43:41]), {16'd0, cur_count}, {16'd0, VEC[i][15:0]});
    end

    // R1: zero count runs 65536 ticks
    do_load(3'd0, 16'd0, 1'b0);
    check("R1", {16'd0, cur_count}, 32'd0);
    do_ticks(65535);
    check("R1", {15'd0, out_level, cur_count}, {15'd0, 1'b0, 16'h0001});
    do_ticks(1);
    check("R1", {15'd0, out_level, cur_count}, {15'd0, 1'b1, 16'h0000});

    // R10: gate low pauses mode 0 and mode 4
    do_load(3'd0, 16'd4, 1'b0);
    gate = 1'b0;
    do_ticks(3);
    check("R10", {15'd0, out_level, cur_count}, {15'd0, 1'b0, 16'h0004});
    gate = 1'b1;
    do_ticks(4);
    check("R10", {31'd0, out_level}, 32'd1);
    do_load(3'd4, 16'd2, 1'b0);
    gate = 1'b0;
    do_ticks(5);
    check("R10", {15'd0, out_level, cur_count}, {15'd0, 1'b0, 16'h0002});
    gate = 1'b1;
    do_ticks(2);
    check("R10", {31'd0, out_level}, 32'd1);

    // R3: one-shot retrigger
    do_load(3'd1, 16'd4, 1'b0);
    do_ticks(3);
    retrigger();
    check("R3", {15'd0, out_level, cur_count}, {15'd0, 1'b0, 16'h0004});
    do_ticks(3);
    check("R3", {31'd0, out_level}, 32'd0);
    do_ticks(1);
    check("R3", {31'd0, out_level}, 32'd1);

    // R7: gate strobe restarts after expiry
    do_load(3'd5, 16'd3, 1'b0);
    do_ticks(5);
    check("R7", {15'd0, out_level, cur_count}, {15'd0, 1'b0, 16'hFFFE});
    retrigger();
    check("R7", {16'd0, cur_count}, 32'd3);
    do_ticks(3);
    check("R7", {31'd0, out_level}, 32'd1);

    // R4 / R5: period restart on gate edge
    do_load(3'd2, 16'd4, 1'b0);
    do_ticks(2);
    retrigger();
    check("R4", {15'd0, out_level, cur_count}, {15'd0, 1'b0, 16'h0004});
    do_load(3'd3, 16'd6, 1'b0);
    do_ticks(4);
    check("R5", {31'd0, out_level}, 32'd0);
    retrigger();
    check("R5", {15'd0, out_level, cur_count}, {15'd0, 1'b1, 16'h0006});

    // R11: reload mid-run, and tick coinciding with load
    do_load(3'd0, 16'd3, 1'b0);
    do_ticks(3);
    check("R11", {31'd0, out_level}, 32'd1);
    load_mode = 3'd0; load_value = 16'd10; load_stb = 1'b1; tick_en = 1'b1;
    @(negedge clk);
    load_stb = 1'b0; tick_en = 1'b0;
    check("R11", {15'd0, out_level, cur_count}, {15'd0, 1'b0, 16'h000A});

    // R12: wrap continues in one-shot mode 1
    do_load(3'd1, 16'd2, 1'b0);
    do_ticks(4);
    check("R12", {15'd0, out_level, cur_count}, {15'd0, 1'b1, 16'hFFFE});

    // R13: latch holds, bcd flag stored
    do_load(3'd2, 16'd100, 1'b1);
    check("R13", {31'd0, cfg_bcd}, 32'd1);
    do_ticks(10);
    latch_stb = 1'b1;
    @(negedge clk);
    latch_stb = 1'b0;
    do_ticks(5);
    check("R13", {16'd0, held_count}, 32'd90);
    check("R13", {16'd0, cur_count}, 32'd85);

    finish_run();
  end
endmodule